// File: doc/BRIEF.md
# Feed-Protected Clock Multiplier Control Bank

This block is the software-facing register bank for a clock multiplier. Software writes an enable bit, a connect bit, a multiplier value and a divider value through a simple register bus. Those writes only reach holding registers. The values that drive the multiplier sit in a second set of shadow registers. A shadow register changes only when software writes a two-word unlock pattern to a dedicated feed register. This stops a stray store from retuning or switching the system clock.

A status register returns the shadow values, not the pending holding values, together with the live lock indication from the loop. The connect output that picks the multiplied clock is gated by the shadow enable bit, the shadow connect bit and the lock input. The clock switch therefore never selects an unlocked loop. The bus read path is combinational: `bus_rdata` is valid in the same cycle as `bus_re` and is zero when no read is made.

Top module: `clkmul_ctrl_bank`

## Requirements
- R1: After reset, `pll_en`, `pll_conn`, `pll_mul` and `pll_div` are zero, and reads of offsets 0x80, 0x84, 0x88 and 0x8C return zero.
- R2: A write to offset 0x80 (control: bit 0 enable, bit 1 connect) or to offset 0x84 (configuration: multiplier in bits 14:0, divider in bits 23:16) changes only the holding register. A read of that offset returns the written value, and the outputs do not change.
- R3: A write of 0x000000AA to offset 0x8C, followed on the next bus access by a write of 0x00000055 to offset 0x8C, copies both holding registers into the shadow registers. The outputs show the new values from the clock edge that samples the 0x55 write. Cycles with no bus access between the two writes do not break the sequence.
- R4: The sequence is aborted, and the shadow registers stay unchanged, in each of these cases: any other read or write comes between the two feed writes; the second feed value is not 0x55; the first feed value is not 0xAA.
- R5: A read of offset 0x88 (status) returns the shadow multiplier in bits 14:0, the shadow divider in bits 23:16, shadow enable in bit 24, shadow connect in bit 25 and the live `lock_in` value in bit 26. All other bits read zero.
- R6: `pll_conn` is high only while shadow enable, shadow connect and `lock_in` are all high.
- R7: A read of offset 0x8C returns zero and cancels a feed sequence in progress. A write to offset 0x88 has no effect.
- R8: Writes to unused bit positions are dropped, and those positions read zero. Reads of unmapped offsets return zero, and writes to them change nothing.
- R9: `pll_en`, `pll_mul` and `pll_div` always equal the shadow enable, multiplier and divider values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_re`, else zero |
| lock_in | input | 1 | Lock indication from the loop |
| pll_en | output | 1 | Shadow enable to the loop |
| pll_conn | output | 1 | Gated select of the multiplied clock |
| pll_mul | output | 15 | Shadow multiplier value |
| pll_div | output | 8 | Shadow divider value |

## Verification
The bound checker checks these rules on every cycle:
- the shadow outputs hold still unless the cycle carried a 0x55 feed write;
- `pll_conn` is never high without enable and lock;
- status reads mirror the shadow outputs and `lock_in`;
- feed reads and the reserved control bits return zero.

Some behaviours only the bench scenarios can show: that a commit needs the 0xAA write just before it, and that each kind of abort (an interleaved read, an interleaved write, a repeated 0xAA, a wrong value) leaves the shadows intact. The bench drives these orderings against its own model and compares the outputs on every clock.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;

   typedef enum logic {
      FEED_IDLE  = 1'b0,
      FEED_ARMED = 1'b1
   } feed_state_e;

   localparam int unsigned CTRL_BITS  = 2;
   localparam int unsigned CTL_EN_IDX = 0;
   localparam int unsigned CTL_CN_IDX = 1;
   localparam int unsigned DIV_LSB    = 16;
   localparam int unsigned STAT_EN    = 24;
   localparam int unsigned STAT_CN    = 25;
   localparam int unsigned STAT_LK    = 26;

endpackage

// File: rtl/clkmul_addr_dec.sv
module clkmul_addr_dec #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned BASE_OFS = 8'h80
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              sel_ctrl,
   output logic              sel_cfg,
   output logic              sel_stat,
   output logic              sel_feed
);
   localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(BASE_OFS);
   localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(BASE_OFS + 4);
   localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(BASE_OFS + 8);
   localparam logic [ADDR_W-1:0] OFS_FEED = ADDR_W'(BASE_OFS + 12);

   always_comb begin
      sel_ctrl = (addr == OFS_CTRL);
      sel_cfg  = (addr == OFS_CFG);
      sel_stat = (addr == OFS_STAT);
      sel_feed = (addr == OFS_FEED);
   end
endmodule

// File: rtl/clkmul_feed_seq.sv
module clkmul_feed_seq
   import clkmul_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned KEY_CMP_W = 32,
   parameter logic [31:0] KEY_FIRST = 32'h0000_00AA,
   parameter logic [31:0] KEY_LAST  = 32'h0000_0055
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              feed_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              commit
);
   feed_state_e st_q, st_d;
   logic        hit_first, hit_last;

   generate
      if (KEY_CMP_W >= DATA_W) begin : g_full_cmp
         always_comb begin
            hit_first = (wdata == DATA_W'(KEY_FIRST));
            hit_last  = (wdata == DATA_W'(KEY_LAST));
         end
      end else begin : g_part_cmp
         always_comb begin
            hit_first = (wdata[KEY_CMP_W-1:0] == KEY_FIRST[KEY_CMP_W-1:0]);
            hit_last  = (wdata[KEY_CMP_W-1:0] == KEY_LAST[KEY_CMP_W-1:0]);
         end
      end
   endgenerate

   always_comb begin
      st_d   = st_q;
      commit = 1'b0;
      if (acc) begin
         st_d = FEED_IDLE;
         if (feed_wr) begin
            if (st_q == FEED_ARMED) begin
               commit = hit_last;
            end else if (hit_first) begin
               st_d = FEED_ARMED;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= FEED_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/clkmul_hold_shadow.sv
module clkmul_hold_shadow #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold_we,
   input  logic [W-1:0] hold_wdata,
   input  logic         commit,
   output logic [W-1:0] hold_q,
   output logic [W-1:0] shadow_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         shadow_q <= '0;
      end else begin
         if (hold_we) hold_q   <= hold_wdata;
         if (commit)  shadow_q <= hold_q;
      end
   end
endmodule

// File: rtl/clkmul_ctrl_bank.sv
module clkmul_ctrl_bank
   import clkmul_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MUL_W     = 15,
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned BASE_OFS  = 8'h80,
   parameter int unsigned KEY_CMP_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              lock_in,
   output logic              pll_en,
   output logic              pll_conn,
   output logic [MUL_W-1:0]  pll_mul,
   output logic [DIV_W-1:0]  pll_div
);
   localparam int unsigned CFG_W = MUL_W + DIV_W;

   generate
      if (MUL_W < 1 || MUL_W > DIV_LSB) begin : g_bad_mul
         $error("MUL_W must be 1..16");
      end
      if (DIV_W < 1 || DIV_W > STAT_EN - DIV_LSB) begin : g_bad_div
         $error("DIV_W must be 1..8");
      end
      if (DATA_W < STAT_LK + 1) begin : g_bad_data
         $error("DATA_W too narrow for status");
      end
      if (KEY_CMP_W < 8) begin : g_bad_key
         $error("KEY_CMP_W must cover the key byte");
      end
   endgenerate

   logic sel_ctrl, sel_cfg, sel_stat, sel_feed;
   logic acc, commit;
   logic [CTRL_BITS-1:0] ctl_hold, ctl_shadow;
   logic [CFG_W-1:0]     cfg_hold, cfg_shadow, cfg_wr;

   clkmul_addr_dec #(.ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)) dec_i (
      .addr(bus_addr), .sel_ctrl(sel_ctrl), .sel_cfg(sel_cfg),
      .sel_stat(sel_stat), .sel_feed(sel_feed)
   );

   assign acc = bus_we | bus_re;

   clkmul_feed_seq #(.DATA_W(DATA_W), .KEY_CMP_W(KEY_CMP_W)) feed_i (
      .clk(clk), .rst_n(rst_n), .acc(acc),
      .feed_wr(bus_we & sel_feed), .wdata(bus_wdata), .commit(commit)
   );

   assign cfg_wr = {bus_wdata[DIV_LSB +: DIV_W], bus_wdata[MUL_W-1:0]};

   clkmul_hold_shadow #(.W(CTRL_BITS)) ctl_i (
      .clk(clk), .rst_n(rst_n), .hold_we(bus_we & sel_ctrl),
      .hold_wdata(bus_wdata[CTRL_BITS-1:0]), .commit(commit),
      .hold_q(ctl_hold), .shadow_q(ctl_shadow)
   );

   clkmul_hold_shadow #(.W(CFG_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .hold_we(bus_we & sel_cfg),
      .hold_wdata(cfg_wr), .commit(commit),
      .hold_q(cfg_hold), .shadow_q(cfg_shadow)
   );

   assign pll_en   = ctl_shadow[CTL_EN_IDX];
   assign pll_conn = ctl_shadow[CTL_EN_IDX] & ctl_shadow[CTL_CN_IDX] & lock_in;
   assign pll_mul  = cfg_shadow[MUL_W-1:0];
   assign pll_div  = cfg_shadow[CFG_W-1:MUL_W];

   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         if (sel_ctrl) begin
            bus_rdata[CTRL_BITS-1:0] = ctl_hold;
         end else if (sel_cfg) begin
            bus_rdata[MUL_W-1:0]       = cfg_hold[MUL_W-1:0];
            bus_rdata[DIV_LSB +: DIV_W] = cfg_hold[CFG_W-1:MUL_W];
         end else if (sel_stat) begin
            bus_rdata[MUL_W-1:0]       = pll_mul;
            bus_rdata[DIV_LSB +: DIV_W] = pll_div;
            bus_rdata[STAT_EN]         = ctl_shadow[CTL_EN_IDX];
            bus_rdata[STAT_CN]         = ctl_shadow[CTL_CN_IDX];
            bus_rdata[STAT_LK]         = lock_in;
         end
      end
   end
endmodule

// File: rtl/clkmul_ctrl_chk.sv
module clkmul_ctrl_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned MUL_W    = 15,
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned BASE_OFS = 8'h80
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_re,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              lock_in,
   input logic              pll_en,
   input logic              pll_conn,
   input logic [MUL_W-1:0]  pll_mul,
   input logic [DIV_W-1:0]  pll_div
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_OFS);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_OFS + 8);
   localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(BASE_OFS + 12);

   a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == A_FEED && bus_wdata == DATA_W'(32'h55))
      |=> ($stable(pll_mul) && $stable(pll_div) && $stable(pll_en)));

   a_r6_conn_gate: assert property (@(posedge clk) disable iff (!rst_n)
      pll_conn |-> (pll_en && lock_in));

   a_r5_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && bus_addr == A_STAT)
      |-> (bus_rdata[26] == lock_in && bus_rdata[24] == pll_en &&
           bus_rdata[MUL_W-1:0] == pll_mul && bus_rdata[16 +: DIV_W] == pll_div));

   a_r7_feed_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && bus_addr == A_FEED) |-> (bus_rdata == '0));

   a_r8_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == A_CTRL) |-> (bus_rdata[DATA_W-1:2] == '0));
endmodule

bind clkmul_ctrl_bank clkmul_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MUL_W(MUL_W), .DIV_W(DIV_W), .BASE_OFS(BASE_OFS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
   .lock_in(lock_in), .pll_en(pll_en), .pll_conn(pll_conn),
   .pll_mul(pll_mul), .pll_div(pll_div)
);

// File: tb/clkmul_ctrl_bank_tb.sv
module clkmul_ctrl_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        lock_in = 1'b0;
   logic        pll_en, pll_conn;
   logic [14:0] pll_mul;
   logic [7:0]  pll_div;

   always #2 clk = ~clk;

   clkmul_ctrl_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .lock_in(lock_in), .pll_en(pll_en), .pll_conn(pll_conn),
      .pll_mul(pll_mul), .pll_div(pll_div)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // reference model
   int unsigned m_hctl = 0, m_hcfg = 0, m_sctl = 0, m_scfg = 0;
   bit m_armed = 0;

   task automatic chk(input bit ok, input string req, input int unsigned act,
                      input int unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic int unsigned model_read(input int unsigned a);
      case (a)
         32'h80:  return m_hctl;
         32'h84:  return m_hcfg;
         32'h88:  return m_scfg | (m_sctl << 24) | (int'(lock_in) << 26);
         default: return 0;
      endcase
   endfunction

   function automatic void model_access(input bit wr, input int unsigned a,
                                        input int unsigned d);
      bit arm_next = 0;
      if (wr && a == 32'h8C) begin
         if (m_armed) begin
            if (d == 32'h55) begin
               m_sctl = m_hctl;
               m_scfg = m_hcfg;
            end
         end else if (d == 32'hAA) begin
            arm_next = 1;
         end
      end else if (wr && a == 32'h80) begin
         m_hctl = d & 32'h3;
      end else if (wr && a == 32'h84) begin
         m_hcfg = d & 32'h00FF_7FFF;
      end
      m_armed = arm_next;
   endfunction

   task automatic wr(input int unsigned a, input int unsigned d);
      @(negedge clk);
      bus_addr = a[7:0]; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
      @(posedge clk);
      model_access(1'b1, a, d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int unsigned a, input string req);
      int unsigned exp;
      @(negedge clk);
      bus_addr = a[7:0]; bus_re = 1'b1; bus_we = 1'b0;
      #1;
      exp = model_read(a);
      chk(bus_rdata == exp, req, bus_rdata, exp);
      @(posedge clk);
      model_access(1'b0, a, 0);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
   endtask

   // per-clock comparison of outputs against the model (R6, R9)
   always @(posedge clk) begin
      #1;
      if (rst_n && !finished) begin
         chk(pll_en == m_sctl[0], "R9 pll_en", pll_en, m_sctl[0]);
         chk(pll_mul == m_scfg[14:0], "R9 pll_mul", pll_mul, m_scfg[14:0]);
         chk(pll_div == m_scfg[23:16], "R9 pll_div", pll_div, m_scfg[23:16]);
         chk(pll_conn == (m_sctl[0] & m_sctl[1] & lock_in), "R6 pll_conn",
             pll_conn, m_sctl[0] & m_sctl[1] & lock_in);
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 20000 && !finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=<20000", wd);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      #1 chk({pll_en, pll_conn, pll_mul, pll_div} == '0, "R1 outputs in reset",
             {pll_en, pll_conn, pll_mul, pll_div}, 0);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset reads
      rd(32'h80, "R1 ctrl reset"); rd(32'h84, "R1 cfg reset");
      rd(32'h88, "R1 stat reset"); rd(32'h8C, "R1 feed reset");
      // R2 holding writes, reserved bits dropped (R8)
      wr(32'h80, 32'hFFFF_FFFF); rd(32'h80, "R2 R8 ctrl hold");
      wr(32'h84, 32'hFFFF_FFFF); rd(32'h84, "R2 R8 cfg hold");
      rd(32'h88, "R5 stat shows shadow not pending");
      wr(32'h84, 32'h0012_0123); wr(32'h80, 32'h3);
      // R3 valid feed
      wr(32'h8C, 32'hAA); wr(32'h8C, 32'h55);
      rd(32'h88, "R3 R5 stat after feed");
      // R6 lock gating
      @(negedge clk) lock_in = 1'b1; idle(2);
      rd(32'h88, "R5 stat lock bit");
      @(negedge clk) lock_in = 1'b0; idle(2);
      @(negedge clk) lock_in = 1'b1;
      // R3 idle cycles between feed writes
      wr(32'h84, 32'h0003_7FFF);
      wr(32'h8C, 32'hAA); idle(4); wr(32'h8C, 32'h55);
      rd(32'h88, "R3 feed with gaps");
      // R4 aborts
      wr(32'h84, 32'h00AB_0042); wr(32'h80, 32'h1);
      wr(32'h8C, 32'hAA); rd(32'h80, "R4 interleaved read"); wr(32'h8C, 32'h55);
      rd(32'h88, "R4 abort by read");
      wr(32'h8C, 32'hAA); wr(32'h84, 32'h00AB_0042); wr(32'h8C, 32'h55);
      rd(32'h88, "R4 abort by write");
      wr(32'h8C, 32'hAA); wr(32'h8C, 32'h56);
      rd(32'h88, "R4 wrong second value");
      wr(32'h8C, 32'hAA); wr(32'h8C, 32'hAA); wr(32'h8C, 32'h55);
      rd(32'h88, "R4 repeated first key");
      wr(32'h8C, 32'h1AA); wr(32'h8C, 32'h55);
      rd(32'h88, "R4 wrong first value");
      // R7 feed read cancels
      wr(32'h8C, 32'hAA); rd(32'h8C, "R7 feed read zero"); wr(32'h8C, 32'h55);
      rd(32'h88, "R7 cancelled by feed read");
      // R7 status write ignored, R8 unmapped
      wr(32'h88, 32'hFFFF_FFFF); rd(32'h88, "R7 stat write ignored");
      wr(32'h90, 32'hFFFF_FFFF); rd(32'h90, "R8 unmapped read");
      rd(32'h80, "R8 ctrl after unmapped write");
      rd(32'h84, "R8 cfg after unmapped write");
      // final commit of the pending values
      wr(32'h8C, 32'hAA); wr(32'h8C, 32'h55);
      rd(32'h88, "R3 final commit");
      idle(2);
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule